// File: doc/BRIEF.md
# USB Peripheral Suspend and Remote-Wakeup Sequencer

This block is the power-management sequencer for a full-speed USB peripheral. It watches the bus line state. When the bus stays idle long enough, it raises a sticky suspend interrupt flag. It never powers the device down on its own. Firmware reacts to the flag and sets a power-down control bit, and only then does the block drop the oscillator enable.

While powered down, the block watches for wake indications: D+ pulled low, or any host-interface traffic. Either one raises a wake interrupt flag. Firmware leaves power-down by clearing the control bit. A reset also leaves power-down.

Firmware can also request a remote wakeup with a set strobe. The block then restarts the oscillator and waits for the oscillator-stable indication. After that it drives a K-state on the bus for a self-timed interval, and the request clears itself when that interval ends. An oscillator-ok flag reports each time clocking becomes stable after reset or after the oscillator is re-enabled.

All intervals are counted in clock cycles and set by parameters. At 48 MHz the defaults are 144000 cycles (3 ms of idle) and 480000 cycles (10 ms of K drive).

Top module: `usb_suspend_seq`

## Requirements
- R1: `line_state_i` is {D+, D-}, with J = 2'b10, K = 2'b01 and SE0 = 2'b00. The suspend flag sets after `IDLE_CYCLES` consecutive clock edges that sample J. Any sample that is not J restarts the count. The flag stays set until it is cleared.
- R2: `irq_o` is high exactly when `ie_i` is set and at least one flag is set whose own enable is also set (suspend, wake, oscillator-ok). A set suspend flag does not raise `irq_o` if either `ie_i` or `susp_ie_i` is low.
- R3: Setting the suspend flag leaves `osc_en_o` high.
- R4: While no remote wakeup is in progress, `osc_en_o` drops one edge after `pwrdown_i` is seen high. `irq_o` keeps its value across power-down.
- R5: While powered down, a sample with D+ low (K or SE0) or a high `host_activity_i` sets the wake flag. Outside power-down, neither one sets it.
- R6: Once `pwrdown_i` is seen low in power-down, `osc_en_o` returns high at the next edge.
- R7: A `rwu_set_i` pulse raises `osc_en_o` and `rwu_busy_o` at the next edge. The block then waits, with `kdrive_o` low, until `osc_stable_i` is seen high. After that, `kdrive_o` is high for exactly `KDRIVE_CYCLES` cycles.
- R8: When the K drive ends, `rwu_busy_o` clears by itself. The block returns to power-down if `pwrdown_i` is still set, and to running otherwise.
- R9: The oscillator-ok flag sets at the first edge where `osc_stable_i` is high with the oscillator enabled, after reset or after each re-enable of the oscillator.
- R10: Each flag clears on its own one-cycle clear strobe (write-one-to-clear). A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_state_i | input | 2 | Sampled bus state {D+, D-} |
| host_activity_i | input | 1 | Host-interface traffic strobe |
| pwrdown_i | input | 1 | Power-down control bit |
| rwu_set_i | input | 1 | Remote-wakeup request set strobe |
| osc_stable_i | input | 1 | Oscillator/clock-stable indication |
| ie_i | input | 1 | Global interrupt enable |
| susp_ie_i | input | 1 | Suspend interrupt enable |
| wake_ie_i | input | 1 | Wake interrupt enable |
| osc_ok_ie_i | input | 1 | Oscillator-ok interrupt enable |
| susp_clr_i | input | 1 | Clear strobe for the suspend flag |
| wake_clr_i | input | 1 | Clear strobe for the wake flag |
| osc_ok_clr_i | input | 1 | Clear strobe for the oscillator-ok flag |
| osc_en_o | output | 1 | Oscillator enable |
| kdrive_o | output | 1 | Drive K-state on the bus |
| rwu_busy_o | output | 1 | Remote-wakeup request pending/active |
| susp_irq_o | output | 1 | Suspend flag |
| wake_irq_o | output | 1 | Wake flag |
| osc_ok_irq_o | output | 1 | Oscillator-ok flag |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench targets idle runs of exactly `IDLE_CYCLES-1` and `IDLE_CYCLES` samples, and a single K or SE0 sample that splits a long idle run. An off-by-one counter, or a count that fails to restart, would raise the suspend flag one sample early or across the split.

It checks the K-drive length at its last high cycle and at the first low cycle. A timer that ends early or late would be caught there, as would one that starts before the oscillator is stable.

It checks that suspend detection alone keeps the oscillator running. It also checks that wake events are ignored outside power-down. A design that returned to running instead of power-down after a remote wakeup, with the power-down bit still set, would show the oscillator enabled at that point.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN      = 2'd0,
    SEQ_PD       = 2'd1,
    SEQ_OSC_WAIT = 2'd2,
    SEQ_KDRIVE   = 2'd3
  } seq_state_e;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_K   = 2'b01;
  localparam logic [1:0] LS_J   = 2'b10;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_SUSP  = 0;
  localparam int unsigned FLG_WAKE  = 1;
  localparam int unsigned FLG_OSCOK = 2;

  function automatic logic line_is_idle(input logic [1:0] ls);
    return ls == LS_J;
  endfunction

  function automatic logic dplus_low(input logic [1:0] ls);
    return ~ls[1];
  endfunction

  function automatic logic irq_combine(input logic gie,
                                       input logic [NUM_FLAGS-1:0] flags,
                                       input logic [NUM_FLAGS-1:0] enables);
    return gie & (|(flags & enables));
  endfunction

endpackage

// File: rtl/usb_idle_detect.sv
module usb_idle_detect
  import usb_susp_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 144000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_state_i,
  output logic       susp_hit_o
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(IDLE_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] idle_cnt;
  logic          idle_now;

  assign idle_now   = line_is_idle(line_state_i);
  assign susp_hit_o = idle_now && (idle_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (!idle_now) begin
      idle_cnt <= '0;
    end else if (idle_cnt != CNT_SAT) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/usb_wake_seq.sv
module usb_wake_seq
  import usb_susp_pkg::*;
#(
  parameter int unsigned KDRIVE_CYCLES = 480000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdown_i,
  input  logic       rwu_set_i,
  input  logic       osc_stable_i,
  output seq_state_e state_o,
  output logic       osc_en_o,
  output logic       osc_restart_o,
  output logic       kdrive_o,
  output logic       rwu_busy_o,
  output logic       kdone_o
);
  localparam int unsigned KW = (KDRIVE_CYCLES > 1) ? $clog2(KDRIVE_CYCLES) : 1;
  localparam logic [KW-1:0] K_LAST = KW'(KDRIVE_CYCLES - 1);

  seq_state_e state_q, state_d;
  logic [KW-1:0] kcnt;
  logic          osc_en_q;

  assign kdone_o = (state_q == SEQ_KDRIVE) && (kcnt == K_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_RUN: begin
        if (rwu_set_i)      state_d = SEQ_OSC_WAIT;
        else if (pwrdown_i) state_d = SEQ_PD;
      end
      SEQ_PD: begin
        if (rwu_set_i)       state_d = SEQ_OSC_WAIT;
        else if (!pwrdown_i) state_d = SEQ_RUN;
      end
      SEQ_OSC_WAIT: begin
        if (osc_stable_i) state_d = SEQ_KDRIVE;
      end
      SEQ_KDRIVE: begin
        if (kdone_o) state_d = pwrdown_i ? SEQ_PD : SEQ_RUN;
      end
      default: state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_RUN;
      kcnt     <= '0;
      osc_en_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      osc_en_q <= osc_en_o;
      if (state_q != SEQ_KDRIVE) kcnt <= '0;
      else if (!kdone_o)         kcnt <= kcnt + 1'b1;
    end
  end

  assign state_o       = state_q;
  assign osc_en_o      = (state_q != SEQ_PD);
  assign osc_restart_o = osc_en_o && !osc_en_q;
  assign kdrive_o      = (state_q == SEQ_KDRIVE);
  assign rwu_busy_o    = (state_q == SEQ_OSC_WAIT) || (state_q == SEQ_KDRIVE);
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
  import usb_susp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  input  logic                 osc_restart_i,
  input  logic                 osc_en_i,
  input  logic                 osc_stable_i,
  output logic                 osc_ok_evt_o,
  output logic [NUM_FLAGS-1:0] flag_o
);
  logic stable_pending;

  assign osc_ok_evt_o = osc_en_i && osc_stable_i && (stable_pending || osc_restart_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             stable_pending <= 1'b1;
    else if (osc_ok_evt_o)  stable_pending <= 1'b0;
    else if (osc_restart_i) stable_pending <= 1'b1;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_suspend_seq.sv
module usb_suspend_seq
  import usb_susp_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES   = 144000,
  parameter int unsigned KDRIVE_CYCLES = 480000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_state_i,
  input  logic       host_activity_i,
  input  logic       pwrdown_i,
  input  logic       rwu_set_i,
  input  logic       osc_stable_i,
  input  logic       ie_i,
  input  logic       susp_ie_i,
  input  logic       wake_ie_i,
  input  logic       osc_ok_ie_i,
  input  logic       susp_clr_i,
  input  logic       wake_clr_i,
  input  logic       osc_ok_clr_i,
  output logic       osc_en_o,
  output logic       kdrive_o,
  output logic       rwu_busy_o,
  output logic       susp_irq_o,
  output logic       wake_irq_o,
  output logic       osc_ok_irq_o,
  output logic       irq_o
);
  seq_state_e           seq_state;
  logic                 susp_hit;
  logic                 wake_evt;
  logic                 osc_ok_evt;
  logic                 osc_restart;
  logic                 kdone;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags, flag_en;

  usb_idle_detect #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_state_i (line_state_i),
    .susp_hit_o   (susp_hit)
  );

  usb_wake_seq #(.KDRIVE_CYCLES(KDRIVE_CYCLES)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwrdown_i     (pwrdown_i),
    .rwu_set_i     (rwu_set_i),
    .osc_stable_i  (osc_stable_i),
    .state_o       (seq_state),
    .osc_en_o      (osc_en_o),
    .osc_restart_o (osc_restart),
    .kdrive_o      (kdrive_o),
    .rwu_busy_o    (rwu_busy_o),
    .kdone_o       (kdone)
  );

  assign wake_evt = (seq_state == SEQ_PD) &&
                    (dplus_low(line_state_i) || host_activity_i);

  assign flag_set[FLG_SUSP]  = susp_hit;
  assign flag_set[FLG_WAKE]  = wake_evt;
  assign flag_set[FLG_OSCOK] = osc_ok_evt;
  assign flag_clr[FLG_SUSP]  = susp_clr_i;
  assign flag_clr[FLG_WAKE]  = wake_clr_i;
  assign flag_clr[FLG_OSCOK] = osc_ok_clr_i;
  assign flag_en[FLG_SUSP]   = susp_ie_i;
  assign flag_en[FLG_WAKE]   = wake_ie_i;
  assign flag_en[FLG_OSCOK]  = osc_ok_ie_i;

  usb_irq_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_i         (flag_set),
    .clr_i         (flag_clr),
    .osc_restart_i (osc_restart),
    .osc_en_i      (osc_en_o),
    .osc_stable_i  (osc_stable_i),
    .osc_ok_evt_o  (osc_ok_evt),
    .flag_o        (flags)
  );

  assign susp_irq_o   = flags[FLG_SUSP];
  assign wake_irq_o   = flags[FLG_WAKE];
  assign osc_ok_irq_o = flags[FLG_OSCOK];
  assign irq_o        = irq_combine(ie_i, flags, flag_en);
endmodule

// File: rtl/usb_suspend_seq_chk.sv
module usb_suspend_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] line_state_i,
  input logic       pwrdown_i,
  input logic       osc_stable_i,
  input logic       ie_i,
  input logic       susp_clr_i,
  input logic       osc_en_o,
  input logic       kdrive_o,
  input logic       rwu_busy_o,
  input logic       susp_irq_o,
  input logic       wake_irq_o,
  input logic       irq_o,
  input logic       susp_hit
);
  AST_SUSP_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    susp_hit |=> susp_irq_o); // R1
  AST_SUSP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_irq_o && !susp_clr_i) |=> susp_irq_o); // R10
  AST_SUSP_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_irq_o) |-> $past(line_state_i == 2'b10)); // R1
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ie_i); // R2
  AST_OSC_OFF_ONLY_PD: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en_o |-> $past(pwrdown_i)); // R4
  AST_WAKE_ONLY_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq_o) |-> $past(!osc_en_o)); // R5
  AST_KDRIVE_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    kdrive_o |-> osc_en_o); // R7
  AST_KDRIVE_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kdrive_o) |-> $past(osc_stable_i)); // R7
  AST_BUSY_ENDS_AFTER_K: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rwu_busy_o) |-> $past(kdrive_o)); // R8
endmodule

bind usb_suspend_seq usb_suspend_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_state_i (line_state_i),
  .pwrdown_i    (pwrdown_i),
  .osc_stable_i (osc_stable_i),
  .ie_i         (ie_i),
  .susp_clr_i   (susp_clr_i),
  .osc_en_o     (osc_en_o),
  .kdrive_o     (kdrive_o),
  .rwu_busy_o   (rwu_busy_o),
  .susp_irq_o   (susp_irq_o),
  .wake_irq_o   (wake_irq_o),
  .irq_o        (irq_o),
  .susp_hit     (susp_hit)
);

// File: tb/usb_suspend_seq_bench.sv
`timescale 1ns/1ps
module usb_suspend_seq_bench;
  localparam int unsigned IDLE = 20;
  localparam int unsigned KCYC = 12;
  localparam logic [1:0] J = 2'b10, K = 2'b01, SE0 = 2'b00;

  // {non-idle code, idle run length, expected suspend flag}
  localparam logic [7:0] VEC [0:5] = '{
    {2'b01, 5'd19, 1'b0},
    {2'b01, 5'd20, 1'b1},
    {2'b00, 5'd19, 1'b0},
    {2'b00, 5'd21, 1'b1},
    {2'b01, 5'd1,  1'b0},
    {2'b00, 5'd31, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] line = J;
  logic hact = 0, pwrdn = 0, rwu = 0, ostab = 0;
  logic ie = 0, sie = 0, wie = 0, oie = 0;
  logic sclr = 0, wclr = 0, oclr = 0;
  logic osc_en, kdrv, busy, sirq, wirq, oirq, irq;
  int ncmp = 0, nfail = 0, cyc = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  usb_suspend_seq #(.IDLE_CYCLES(IDLE), .KDRIVE_CYCLES(KCYC)) u_usb_suspend_seq (
    .clk(clk), .rst_n(rst_n), .line_state_i(line), .host_activity_i(hact),
    .pwrdown_i(pwrdn), .rwu_set_i(rwu), .osc_stable_i(ostab), .ie_i(ie),
    .susp_ie_i(sie), .wake_ie_i(wie), .osc_ok_ie_i(oie), .susp_clr_i(sclr),
    .wake_clr_i(wclr), .osc_ok_clr_i(oclr), .osc_en_o(osc_en), .kdrive_o(kdrv),
    .rwu_busy_o(busy), .susp_irq_o(sirq), .wake_irq_o(wirq),
    .osc_ok_irq_o(oirq), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string what, input logic act, input logic exp);
    ncmp++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R4 reset osc_en", osc_en, 1'b1);
    chk("R7 reset kdrive", kdrv, 1'b0);
    chk("R1 reset susp flag", sirq, 1'b0);
    chk("R2 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R9 no osc-ok before stable", oirq, 1'b0);
    ostab = 1'b1; tick();
    chk("R9 osc-ok after reset", oirq, 1'b1);
    oclr = 1'b1; tick(); oclr = 1'b0;
    chk("R10 osc-ok cleared", oirq, 1'b0);

    // Table walk: idle-run lengths around the threshold
    for (int i = 0; i < 6; i++) begin
      line = VEC[i][7:6]; sclr = 1'b1; tick(); sclr = 1'b0;
      line = J;
      for (int n = 0; n < int'(VEC[i][5:1]); n++) tick();
      chk($sformatf("R1 vector %0d", i), sirq, VEC[i][0]);
    end

    // Idle run split by one K sample
    line = K; sclr = 1'b1; tick(); sclr = 1'b0;
    line = J; repeat (15) tick();
    line = K; tick();
    line = J; repeat (15) tick();
    chk("R1 split run no flag", sirq, 1'b0);
    repeat (5) tick();
    chk("R1 flag after full run", sirq, 1'b1);
    chk("R3 osc still on", osc_en, 1'b1);

    // Interrupt gating
    ie = 1; sie = 0; #1 chk("R2 susp_ie low", irq, 1'b0);
    ie = 0; sie = 1; #1 chk("R2 ie low", irq, 1'b0);
    ie = 1; sie = 1; #1 chk("R2 both set", irq, 1'b1);

    // Outside power-down, K does not set wake
    line = K; tick(); line = J; tick();
    chk("R5 no wake outside pd", wirq, 1'b0);

    // Power-down
    pwrdn = 1'b1; tick();
    chk("R4 osc off", osc_en, 1'b0);
    chk("R4 irq kept", irq, 1'b1);
    ostab = 1'b0;
    line = K; tick(); line = J;
    chk("R5 wake on D+ low", wirq, 1'b1);
    wclr = 1'b1; tick(); wclr = 1'b0;
    chk("R10 wake cleared", wirq, 1'b0);
    hact = 1'b1; tick(); hact = 1'b0;
    chk("R5 wake on host activity", wirq, 1'b1);

    // Exit by clearing the bit
    pwrdn = 1'b0; tick();
    chk("R6 osc back on", osc_en, 1'b1);
    chk("R9 no osc-ok while unstable", oirq, 1'b0);
    ostab = 1'b1; tick();
    chk("R9 osc-ok after re-enable", oirq, 1'b1);
    oclr = 1'b1; tick(); oclr = 1'b0;

    // Remote wakeup from power-down
    pwrdn = 1'b1; tick(); ostab = 1'b0;
    chk("R4 osc off again", osc_en, 1'b0);
    rwu = 1'b1; tick(); rwu = 1'b0;
    chk("R7 osc restarted", osc_en, 1'b1);
    chk("R7 busy set", busy, 1'b1);
    repeat (3) tick();
    chk("R7 no K before stable", kdrv, 1'b0);
    ostab = 1'b1; tick();
    chk("R7 K starts", kdrv, 1'b1);
    chk("R9 osc-ok on rwu restart", oirq, 1'b1);
    repeat (KCYC - 1) tick();
    chk("R7 K last cycle", kdrv, 1'b1);
    tick();
    chk("R7 K ended", kdrv, 1'b0);
    chk("R8 busy self-clears", busy, 1'b0);
    chk("R8 back to power-down", osc_en, 1'b0);

    // Remote wakeup from run returns to run
    pwrdn = 1'b0; tick();
    rwu = 1'b1; tick(); rwu = 1'b0;
    repeat (KCYC + 1) tick();
    chk("R8 busy cleared from run", busy, 1'b0);
    chk("R8 stays running", osc_en, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end
endmodule